// File: doc/BRIEF.md
# Blocked 3D Array Address Generator

This block turns a packed fixed-point 3D coordinate into a byte offset for a volume stored in small bricks, so that voxels that sit next to each other in space also sit close together in memory. The integer bits of x, y and z are interleaved in three groups. Low and middle groups have fixed widths. The upper x and y groups have a width set by a size code. The upper z group is always four bits wide, and its position moves with that size code.

The block takes the coordinate word, a size code and an element-size select. The assembled index is scaled to a byte offset for 8-, 16- or 32-bit elements. Fractional coordinate bits, and integer bits outside the selected width, do not affect the result. An output register is included by default. It adds one cycle of latency and carries a valid bit alongside the offset. The caller adds any base address.

Top module: `blk3d_addr_gen`

## Requirements
- R1: For 8-bit elements, offset[1:0] = coord[12:11], offset[3:2] = coord[34:33] and offset[4] = coord[55].
- R2: For 8-bit elements, offset[8:5] = coord[16:13], offset[12:9] = coord[38:35] and offset[16:13] = coord[59:56].
- R3: With effective size n, coord[17+i] goes to offset[17+i] and coord[39+i] goes to offset[17+n+i], for every i below n (8-bit elements).
- R4: coord[63:60] goes to offset[17+2n+3 : 17+2n] (8-bit elements).
- R5: elem_sel 0 (8-bit) leaves the assembled index unshifted. elem_sel 1 (16-bit) shifts it left by 1. elem_sel 2 and 3 (32-bit) shift it left by 2.
- R6: A size_code above 5 is handled as 5, and invalid_size is 1 for that result. Otherwise invalid_size is 0.
- R7: Input bits not named in R1 to R4 for the effective size have no effect on the offset. This covers coord[10:0], coord[32:17+n], coord[54:39+n] and the fractional bits.
- R8: With size_code 0, no upper x or y bit reaches the offset, and coord[63:60] lands at offset[20:17].
- R9: out_valid, offset and invalid_size are cleared by reset. A result appears on the outputs exactly one clock edge after in_valid is sampled high, and out_valid follows in_valid with that same delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input coordinate is valid this cycle |
| coord | input | 64 | Packed x, y, z fixed-point coordinate |
| size_code | input | 3 | Number of upper x/y index bits (0..5, larger clamps) |
| elem_sel | input | 2 | Element size: 0 byte, 1 halfword, 2 or 3 word |
| out_valid | output | 1 | Offset is valid |
| offset | output | 64 | Byte offset into the blocked array |
| invalid_size | output | 1 | Size code was above 5 and was clamped |

## Verification
Clamping of the size code and element scaling can act on the same result. With a code of 6 or 7 and 32-bit elements, the upper z group lands at its highest position, and the shift then carries it to bit 32 while the flag must also rise. The sweep covers this by walking a single one across all 64 coordinate bits for every size code and every element select. Each output is compared exactly against an offset the bench builds bit by bit, and the flag is checked for the same cycle.

// File: rtl/blk3d_addr_gen.sv
module blk3d_addr_gen #(
  parameter int  SIZE_MAX = 5,
  parameter bit  OUT_REG  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] coord,
  input  logic [2:0]  size_code,
  input  logic [1:0]  elem_sel,
  output logic        out_valid,
  output logic [63:0] offset,
  output logic        invalid_size
);
  localparam int W       = 64;
  localparam int HI_BASE = 17;
  localparam int XH_SRC  = 17;
  localparam int YH_SRC  = 39;
  localparam int FIX_W   = 17;

  logic          size_bad;
  logic [2:0]    n_eff;
  logic [W-1:0]  hi_mask, x_hi, y_hi, z_hi, idx, scaled;

  assign size_bad = size_code > 3'(SIZE_MAX);
  assign n_eff    = size_bad ? 3'(SIZE_MAX) : size_code;
  assign hi_mask  = (64'd1 << n_eff) - 64'd1;
  assign x_hi     = (coord >> XH_SRC) & hi_mask;
  assign y_hi     = ((coord >> YH_SRC) & hi_mask) << n_eff;
  assign z_hi     = {60'd0, coord[63:60]} << {n_eff, 1'b0};

  assign idx = ((x_hi | y_hi | z_hi) << HI_BASE)
             | {{(W-FIX_W){1'b0}}, coord[59:56], coord[38:35], coord[16:13],
                coord[55], coord[34:33], coord[12:11]};

  always_comb begin
    case (elem_sel)
      2'd0:    scaled = idx;
      2'd1:    scaled = idx << 1;
      default: scaled = idx << 2;
    endcase
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid    <= 1'b0;
          offset       <= '0;
          invalid_size <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            offset       <= scaled;
            invalid_size <= size_bad;
          end
        end
      end

      // R9
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      // R9
      valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      // R1
      low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && elem_sel == 2'd0) |=> offset[1:0] == $past(coord[12:11]));
      // R5
      word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && elem_sel[1]) |=> offset[1:0] == 2'b00);
      // R5
      half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && elem_sel == 2'd1) |=> offset[0] == 1'b0);
      // R6
      clamp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code > 3'd5) |=> invalid_size);
      // R4
      offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> offset[63:33] == '0);
    end else begin : g_comb
      assign out_valid    = in_valid;
      assign offset       = scaled;
      assign invalid_size = size_bad;
    end
  endgenerate
endmodule

// File: tb/blk3d_addr_gen_test.sv
module blk3d_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] coord = '0;
  logic [2:0]  size_code = '0;
  logic [1:0]  elem_sel = '0;
  logic        out_valid;
  logic [63:0] offset;
  logic        invalid_size;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  blk3d_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .coord(coord),
    .size_code(size_code), .elem_sel(elem_sel), .out_valid(out_valid),
    .offset(offset), .invalid_size(invalid_size)
  );

  function automatic logic [63:0] model(logic [63:0] c, int sz, int el);
    logic [63:0] r = '0;
    int n = (sz > 5) ? 5 : sz;
    for (int i = 0; i < 2; i++) begin
      r[i]     = c[11+i];
      r[2+i]   = c[33+i];
    end
    r[4] = c[55];
    for (int i = 0; i < 4; i++) begin
      r[5+i]       = c[13+i];
      r[9+i]       = c[35+i];
      r[13+i]      = c[56+i];
      r[17+2*n+i]  = c[60+i];
    end
    for (int i = 0; i < n; i++) begin
      r[17+i]   = c[17+i];
      r[17+n+i] = c[39+i];
    end
    return (el == 0) ? r : (el == 1) ? (r << 1) : (r << 2);
  endfunction

  function automatic string req_of(int k, int sz, int el);
    if (sz > 5) return "R6";
    if (el != 0) return "R5";
    if (k == 11 || k == 12 || k == 33 || k == 34 || k == 55) return "R1";
    if ((k >= 13 && k <= 16) || (k >= 35 && k <= 38) || (k >= 56 && k <= 59)) return "R2";
    if (k >= 60) return (sz == 0) ? "R8" : "R4";
    if ((k >= 17 && k < 17 + sz) || (k >= 39 && k < 39 + sz)) return "R3";
    return (sz == 0) ? "R8" : "R7";
  endfunction

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [63:0] c, int sz, int el, string req);
    @(negedge clk);
    coord = c; size_code = 3'(sz); elem_sel = 2'(el); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check64(req, offset, model(c, sz, el));
    check64("R6", {63'd0, invalid_size}, {63'd0, sz > 5});
    check64("R9", {63'd0, out_valid}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check64("R9", {62'd0, out_valid, invalid_size}, 64'd0);
    check64("R9", offset, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check64("R9", {63'd0, out_valid}, 64'd0);

    for (int sz = 0; sz < 8; sz++)
      for (int el = 0; el < 4; el++)
        for (int k = 0; k < 64; k++)
          apply(64'd1 << k, sz, el, req_of(k, sz, el));

    for (int sz = 0; sz < 8; sz++)
      for (int el = 0; el < 4; el++) begin
        apply(64'hFFFF_FFFF_FFFF_FFFF, sz, el, "R3");
        apply(64'h0000_07FF_0000_07FF, sz, el, "R7");
        apply(64'hA5C3_96E1_5A3C_691E ^ (64'(sz) << 40) ^ 64'(el), sz, el, "R4");
      end

    @(negedge clk);
    check64("R9", {63'd0, out_valid}, 64'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R9 watchdog actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule